// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

Two independent count channels, each held in a high byte and a low byte, count either an internal tick at one twelfth of the clock rate or falling edges seen on an external pulse input. Each channel has a run bit and can also be gated by an external level pin. One shared 8-bit configuration register gives each channel a nibble: a two-bit count structure, a tick/pulse source select and a gate enable. The four count structures are a 13-bit prescaled counter, a full 16-bit counter, an 8-bit counter that reloads from the high byte, and a split mode. In split mode channel 0 becomes two 8-bit counters, and channel 1 halts.

Software reaches the count bytes, the configuration register and a control register through a byte-wide register port. Each channel raises a sticky overflow flag, and software clears it by writing zero. Every overflow of channel 1's count also produces a one-cycle pulse on a dedicated output, which can drive a baud-rate generator.

Top module: `tmr_pair_top`

## Requirements
- R1: After synchronous reset, every register reads 0x00, both overflow flags are low and no overflow pulse is produced.
- R2: Register addresses: 0 control, 1 configuration, 2 channel 0 low byte, 3 channel 0 high byte, 4 channel 1 low byte, 5 channel 1 high byte. Other addresses read 0x00. Read data is registered: it appears one clock after the address is presented. Control bit 0 is run for channel 0, bit 1 is the channel 0 flag, bit 2 is run for channel 1 and bit 3 is the channel 1 flag. Bits 7:4 read 0. Writing 0 to a flag bit clears it, and writing 1 leaves it unchanged. Configuration bits 3:0 set channel 0 and bits 7:4 set channel 1. Within a nibble, bits 1:0 select the structure (0 = 13-bit, 1 = 16-bit, 2 = reload, 3 = split/halt), bit 2 selects external pulses and bit 3 enables gating.
- R3: In tick mode an enabled channel advances exactly once per 12 clocks. A run interval of 12·N clocks adds exactly N.
- R4: In pulse mode each falling edge on the channel's external input adds exactly one, provided that edges are at least 12 clocks apart.
- R5: With gating enabled, a running channel counts only while its gate pin is high. The pin passes through a two-flop synchroniser, so a high interval of 12·N clocks adds exactly N ticks.
- R6: Structure 0 counts the 5 low bits of the low byte, which carry into the high byte. Low-byte bits 7:5 are never changed by counting. Going past 0xFF/0x1F wraps both parts to zero and sets the flag.
- R7: Structure 1 counts high:low as 16 bits. Going past 0xFFFF wraps to 0x0000 and sets the channel's flag.
- R8: Structure 2 counts the low byte. When the low byte goes past 0xFF it is loaded from the high byte and the flag is set. The high byte is not changed.
- R9: When channel 0 uses structure 3, its low byte is an 8-bit counter under channel 0's controls and sets flag 0 on wrap. Its high byte counts internal ticks under channel 1's run bit and sets flag 1 on wrap.
- R10: When channel 1 uses structure 3, its count bytes do not change.
- R11: While channel 0 is split, channel 1 counts in its own structure whatever its run bit, and its overflows do not set flag 1.
- R12: A register write to a count byte in the same cycle as an increment of that byte takes priority over the increment.
- R13: Each overflow of channel 1's count produces exactly one single-cycle pulse on `baud_ovf`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| ext_pulse | input | 2 | External count inputs, one per channel, counted on falling edges |
| gate_pin | input | 2 | Gate levels, one per channel, high allows counting |
| ovf_flag | output | 2 | Sticky overflow flags (bit 0 channel 0, bit 1 channel 1) |
| baud_ovf | output | 1 | One-cycle pulse on each channel 1 overflow |

## Verification
The assertions assume that the internal tick is never active on two consecutive cycles. They also assume that an external edge is counted only at a tick, which holds only when pulses arrive no faster than one per twelve clocks. The bench therefore spaces external pulses at least fourteen clocks apart and holds each level for several clocks. It opens and closes every counting window with a register write or a gate edge exactly 12·N clocks apart, so the expected counts are exact whatever the prescaler phase. Random start values are drawn near each structure's wrap point, and the bench models the 13-bit, 16-bit and reload arithmetic with its own functions.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    M_13     = 2'd0,
    M_16     = 2'd1,
    M_RELOAD = 2'd2,
    M_SPLIT  = 2'd3
  } tmode_e;

  typedef struct packed {
    logic   gate;
    logic   ext_sel;
    tmode_e mode;
  } chcfg_t;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_CFG  = 3'd1;
  localparam logic [2:0] A_LO0  = 3'd2;
  localparam logic [2:0] A_HI0  = 3'd3;
  localparam logic [2:0] A_LO1  = 3'd4;
  localparam logic [2:0] A_HI1  = 3'd5;
endpackage

// File: rtl/tmr_tick_src.sv
module tmr_tick_src #(
  parameter int DIV = 12,
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] ext_in,
  input  logic [NCH-1:0] gate_in,
  output logic           tick,
  output logic [NCH-1:0] ext_evt,
  output logic [NCH-1:0] gate_ok
);
  localparam int PW = $clog2(DIV);
  localparam logic [PW-1:0] PMAX = PW'(DIV - 1);

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst)               pre_q <= '0;
    else if (pre_q == PMAX) pre_q <= '0;
    else                   pre_q <= pre_q + 1'b1;
  end

  assign tick = (pre_q == PMAX);

  for (genvar i = 0; i < NCH; i++) begin : g_sync
    logic s1_q, s2_q, s3_q, pend_q;
    logic g1_q, g2_q;
    logic fall;

    assign fall = s3_q & ~s2_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        s1_q   <= 1'b1;
        s2_q   <= 1'b1;
        s3_q   <= 1'b1;
        pend_q <= 1'b0;
        g1_q   <= 1'b0;
        g2_q   <= 1'b0;
      end else begin
        s1_q   <= ext_in[i];
        s2_q   <= s1_q;
        s3_q   <= s2_q;
        pend_q <= fall | (pend_q & ~tick);
        g1_q   <= gate_in[i];
        g2_q   <= g1_q;
      end
    end

    assign ext_evt[i] = pend_q & tick;
    assign gate_ok[i] = g2_q;

    AST_EVT_SPACED: assert property (@(posedge clk) disable iff (rst)
      ext_evt[i] |=> !ext_evt[i]); // R4
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick); // R3
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int W         = 8,
  parameter int PRE_W     = 5,
  parameter bit HAS_SPLIT = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  chcfg_t       cfg,
  input  logic         run,
  input  logic         free_run,
  input  logic         run_hi,
  input  logic         tick,
  input  logic         ext_evt,
  input  logic         gate_ok,
  input  logic         wr_lo,
  input  logic         wr_hi,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] lo_q,
  output logic [W-1:0] hi_q,
  output logic         ovf,
  output logic         ovf_hi
);
  localparam logic [W-1:0]     ALL1    = '1;
  localparam logic [PRE_W-1:0] PRE_MAX = '1;

  logic         src, go;
  logic [W-1:0] lo_n, hi_n;

  assign src = cfg.ext_sel ? ext_evt : tick;
  assign go  = (run | free_run) & (~cfg.gate | gate_ok) & src;

  always_comb begin
    lo_n   = lo_q;
    hi_n   = hi_q;
    ovf    = 1'b0;
    ovf_hi = 1'b0;
    case (cfg.mode)
      M_13: begin
        if (go) begin
          if (lo_q[PRE_W-1:0] == PRE_MAX) begin
            lo_n[PRE_W-1:0] = '0;
            hi_n            = hi_q + 1'b1;
            ovf             = (hi_q == ALL1);
          end else begin
            lo_n[PRE_W-1:0] = lo_q[PRE_W-1:0] + 1'b1;
          end
        end
      end
      M_16: begin
        if (go) begin
          {hi_n, lo_n} = {hi_q, lo_q} + 1'b1;
          ovf          = (hi_q == ALL1) && (lo_q == ALL1);
        end
      end
      M_RELOAD: begin
        if (go) begin
          if (lo_q == ALL1) begin
            lo_n = hi_q;
            ovf  = 1'b1;
          end else begin
            lo_n = lo_q + 1'b1;
          end
        end
      end
      default: begin
        if (HAS_SPLIT) begin
          if (go) begin
            lo_n = lo_q + 1'b1;
            ovf  = (lo_q == ALL1);
          end
          if (tick && run_hi) begin
            hi_n   = hi_q + 1'b1;
            ovf_hi = (hi_q == ALL1);
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= wr_lo ? wdata : lo_n;
      hi_q <= wr_hi ? wdata : hi_n;
    end
  end

  AST_WRITE_WINS_LO: assert property (@(posedge clk) disable iff (rst)
    wr_lo |=> lo_q == $past(wdata)); // R12
  AST_WRITE_WINS_HI: assert property (@(posedge clk) disable iff (rst)
    wr_hi |=> hi_q == $past(wdata)); // R12
  AST_RELOAD_FROM_HI: assert property (@(posedge clk) disable iff (rst)
    (cfg.mode == M_RELOAD && go && lo_q == ALL1 && !wr_lo) |=> lo_q == $past(hi_q)); // R8
  AST_M13_UPPER_KEPT: assert property (@(posedge clk) disable iff (rst)
    (cfg.mode == M_13 && !wr_lo) |=> lo_q[W-1:PRE_W] == $past(lo_q[W-1:PRE_W])); // R6

  if (!HAS_SPLIT) begin : g_halt_chk
    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (cfg.mode == M_SPLIT && !wr_lo && !wr_hi) |=> ($stable(lo_q) && $stable(hi_q))); // R10
  end
endmodule

// File: rtl/tmr_pair_top.sv
module tmr_pair_top
  import tmr_pkg::*;
#(
  parameter int DIV   = 12,
  parameter int PRE_W = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic [1:0] ext_pulse,
  input  logic [1:0] gate_pin,
  output logic [1:0] ovf_flag,
  output logic       baud_ovf
);
  localparam int NCH = 2;
  localparam int W   = 8;

  logic [W-1:0]   cfg_q;
  logic [NCH-1:0] run_q, flag_q, flag_set;
  logic [NCH-1:0] ext_evt, gate_ok, ovf_m, ovf_h;
  logic           tick, split0, wr_ctrl;
  logic [W-1:0]   lo [NCH];
  logic [W-1:0]   hi [NCH];
  chcfg_t         cfg [NCH];

  tmr_tick_src #(.DIV(DIV), .NCH(NCH)) u_tick (
    .clk     (clk),
    .rst     (rst),
    .ext_in  (ext_pulse),
    .gate_in (gate_pin),
    .tick    (tick),
    .ext_evt (ext_evt),
    .gate_ok (gate_ok)
  );

  assign split0  = (cfg[0].mode == M_SPLIT);
  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic wr_lo, wr_hi;
    assign cfg[i] = chcfg_t'(cfg_q[4*i +: 4]);
    assign wr_lo  = reg_wr && (reg_addr == A_LO0 + 3'(2*i));
    assign wr_hi  = reg_wr && (reg_addr == A_HI0 + 3'(2*i));

    tmr_chan #(.W(W), .PRE_W(PRE_W), .HAS_SPLIT(i == 0)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .cfg      (cfg[i]),
      .run      (run_q[i]),
      .free_run ((i == 1) && split0),
      .run_hi   (run_q[1]),
      .tick     (tick),
      .ext_evt  (ext_evt[i]),
      .gate_ok  (gate_ok[i]),
      .wr_lo    (wr_lo),
      .wr_hi    (wr_hi),
      .wdata    (reg_wdata),
      .lo_q     (lo[i]),
      .hi_q     (hi[i]),
      .ovf      (ovf_m[i]),
      .ovf_hi   (ovf_h[i])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        flag_q[i] <= 1'b0;
        run_q[i]  <= 1'b0;
      end else begin
        flag_q[i] <= flag_set[i] | (flag_q[i] & ~(wr_ctrl & ~reg_wdata[2*i+1]));
        if (wr_ctrl) run_q[i] <= reg_wdata[2*i];
      end
    end

    AST_FLAG_ON_OVF: assert property (@(posedge clk) disable iff (rst)
      flag_set[i] |=> flag_q[i]); // R7
  end

  assign flag_set[0] = ovf_m[0];
  assign flag_set[1] = (split0 ? ovf_h[0] : ovf_m[1]) | ovf_h[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q     <= '0;
      reg_rdata <= '0;
      baud_ovf  <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == A_CFG) cfg_q <= reg_wdata;
      baud_ovf <= ovf_m[1];
      case (reg_addr)
        A_CTRL:  reg_rdata <= {4'b0, flag_q[1], run_q[1], flag_q[0], run_q[0]};
        A_CFG:   reg_rdata <= cfg_q;
        A_LO0:   reg_rdata <= lo[0];
        A_HI0:   reg_rdata <= hi[0];
        A_LO1:   reg_rdata <= lo[1];
        A_HI1:   reg_rdata <= hi[1];
        default: reg_rdata <= '0;
      endcase
    end
  end

  assign ovf_flag = flag_q;

  AST_SPLIT_NO_CH1_FLAG: assert property (@(posedge clk) disable iff (rst)
    (split0 && !ovf_h[0] && !flag_q[1] && !wr_ctrl) |=> !flag_q[1]); // R11
endmodule

// File: tb/tmr_pair_top_tb.sv
module tmr_pair_top_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [1:0] ext_pulse = 2'b11;
  logic [1:0] gate_pin = 2'b00;
  logic [1:0] ovf_flag;
  logic       baud_ovf;

  int errors = 0;
  int checks = 0;
  int baud_cnt = 0;
  bit done = 1'b0;

  tmr_pair_top u_dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_pulse(ext_pulse),
    .gate_pin(gate_pin), .ovf_flag(ovf_flag), .baud_ovf(baud_ovf)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (!rst && baud_ovf) baud_cnt++;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  // open a window with d_on, close it with d_off exactly 12*n clocks later
  task automatic window(input logic [2:0] a, input logic [7:0] d_on,
                        input logic [7:0] d_off, input int n);
    wr(a, d_on);
    repeat (12*n - 1) @(negedge clk);
    wr(a, d_off);
  endtask

  function automatic logic [16:0] m1_add(input logic [15:0] v, input int n);
    logic [16:0] s;
    s = {1'b0, v} + 17'(n);
    return s;
  endfunction

  function automatic logic [16:0] m0_add(input logic [7:0] h, input logic [7:0] l, input int n);
    logic f;
    f = 1'b0;
    for (int k = 0; k < n; k++) begin
      if (l[4:0] == 5'h1F) begin
        l[4:0] = 5'h0;
        if (h == 8'hFF) f = 1'b1;
        h = h + 8'd1;
      end else l[4:0] = l[4:0] + 5'd1;
    end
    return {f, h, l};
  endfunction

  function automatic logic [16:0] m2_add(input logic [7:0] h, input logic [7:0] l, input int n);
    logic f;
    f = 1'b0;
    for (int k = 0; k < n; k++) begin
      if (l == 8'hFF) begin l = h; f = 1'b1; end
      else l = l + 8'd1;
    end
    return {f, h, l};
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0]  r, h, l;
    logic [16:0] e;
    int n, b0;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), r);
      check("R1 reset value", r, 0);
    end
    check("R1 flags", ovf_flag, 0);
    check("R1 pulse", baud_cnt, 0);

    // R2 register map
    wr(3'd1, 8'hA5); rd(3'd1, r); check("R2 cfg readback", r, 8'hA5);
    h = 8'($urandom); wr(3'd3, h); rd(3'd3, r); check("R2 hi0 readback", r, h);
    wr(3'd6, 8'h77); rd(3'd6, r); check("R2 unused addr", r, 0);
    wr(3'd0, 8'hF5); rd(3'd0, r); check("R2 ctrl run bits", r, 8'h05);
    wr(3'd0, 8'h0A); rd(3'd0, r); check("R2 flag write-one no effect", r, 8'h00);

    // R3 tick counting, several windows
    wr(3'd1, 8'h11);
    for (int t = 0; t < 3; t++) begin
      n = 1 + int'($urandom % 9);
      l = 8'($urandom % 64);
      wr(3'd2, l); wr(3'd3, 8'h00);
      window(3'd0, 8'h01, 8'h0A, n);
      rd(3'd2, r); check("R3 ticks per 12 clocks", r, int'(l) + n);
    end

    // R7 16-bit wrap, R13 channel 1 pulse
    for (int t = 0; t < 4; t++) begin
      e = 17'(16'hFFF0 + ($urandom % 16));
      h = e[15:8]; l = e[7:0];
      n = 1 + int'($urandom % 20);
      wr(3'd2, l); wr(3'd3, h);
      window(3'd0, 8'h01, 8'h0A, n);
      e = m1_add({h, l}, n);
      rd(3'd2, r); check("R7 low byte", r, e[7:0]);
      rd(3'd3, r); check("R7 high byte", r, e[15:8]);
      check("R7 flag0", ovf_flag[0], e[16]);
      wr(3'd0, 8'h08);
    end
    b0 = baud_cnt;
    wr(3'd4, 8'hFE); wr(3'd5, 8'hFF);
    window(3'd0, 8'h04, 8'h0A, 3);
    rd(3'd4, r); check("R7 ch1 wrap", r, 8'h01);
    check("R7 flag1", ovf_flag[1], 1);
    @(negedge clk);
    check("R13 one pulse per ch1 overflow", baud_cnt - b0, 1);
    wr(3'd0, 8'h00);

    // R6 13-bit structure
    wr(3'd1, 8'h10);
    for (int t = 0; t < 3; t++) begin
      h = (t == 0) ? 8'hFF : 8'(8'hF0 + $urandom % 16);
      l = {3'($urandom), 5'(5'h18 + $urandom % 8)};
      n = 2 + int'($urandom % 40);
      wr(3'd2, l); wr(3'd3, h);
      window(3'd0, 8'h01, 8'h0A, n);
      e = m0_add(h, l, n);
      rd(3'd2, r); check("R6 low part and upper bits kept", r, e[7:0]);
      rd(3'd3, r); check("R6 high byte", r, e[15:8]);
      check("R6 flag0", ovf_flag[0], e[16]);
      wr(3'd0, 8'h08);
    end

    // R8 reload structure
    wr(3'd1, 8'h12);
    for (int t = 0; t < 3; t++) begin
      h = 8'($urandom);
      l = 8'(8'hF8 + $urandom % 8);
      n = 1 + int'($urandom % 12);
      wr(3'd2, l); wr(3'd3, h);
      window(3'd0, 8'h01, 8'h0A, n);
      e = m2_add(h, l, n);
      rd(3'd2, r); check("R8 low after reload", r, e[7:0]);
      rd(3'd3, r); check("R8 high unchanged", r, h);
      check("R8 flag0", ovf_flag[0], e[16]);
      wr(3'd0, 8'h08);
    end

    // R9 channel 0 split
    wr(3'd1, 8'h13);
    wr(3'd0, 8'h00);
    wr(3'd2, 8'hFE); wr(3'd3, 8'hFD);
    window(3'd0, 8'h05, 8'h0A, 3);
    rd(3'd2, r); check("R9 split low", r, 8'h01);
    rd(3'd3, r); check("R9 split high", r, 8'h00);
    check("R9 both flags", ovf_flag, 2'b11);
    wr(3'd0, 8'h00);

    // R11 channel 1 free runs while channel 0 split, no flag1
    wr(3'd1, 8'h11);
    wr(3'd4, 8'hFE); wr(3'd5, 8'hFF);
    b0 = baud_cnt;
    window(3'd1, 8'h13, 8'h11, 3);
    rd(3'd4, r); check("R11 ch1 counts without run", r, 8'h01);
    rd(3'd5, r); check("R11 ch1 high", r, 8'h00);
    check("R11 no flag1", ovf_flag[1], 0);
    @(negedge clk);
    check("R13 pulse while split", baud_cnt - b0, 1);

    // R10 channel 1 halted
    wr(3'd1, 8'h31);
    wr(3'd4, 8'h34); wr(3'd5, 8'h12);
    window(3'd0, 8'h04, 8'h00, 5);
    rd(3'd4, r); check("R10 halted low", r, 8'h34);
    rd(3'd5, r); check("R10 halted high", r, 8'h12);

    // R4 external pulses
    wr(3'd1, 8'h05);
    wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    wr(3'd0, 8'h01);
    n = 3 + int'($urandom % 6);
    for (int k = 0; k < n; k++) begin
      ext_pulse[0] = 1'b0; repeat (4) @(negedge clk);
      ext_pulse[0] = 1'b1; repeat (10 + int'($urandom % 5)) @(negedge clk);
    end
    repeat (30) @(negedge clk);
    wr(3'd0, 8'h0A);
    rd(3'd2, r); check("R4 one count per falling edge", r, n);

    // R5 gate
    wr(3'd1, 8'h09);
    wr(3'd2, 8'h00);
    wr(3'd0, 8'h01);
    repeat (40) @(negedge clk);
    rd(3'd2, r); check("R5 gate low blocks", r, 0);
    n = 2 + int'($urandom % 5);
    gate_pin[0] = 1'b1;
    repeat (12*n) @(negedge clk);
    gate_pin[0] = 1'b0;
    repeat (10) @(negedge clk);
    wr(3'd0, 8'h0A);
    rd(3'd2, r); check("R5 gated ticks", r, n);

    // R12 write beats a coincident increment, swept over prescaler phase
    wr(3'd1, 8'h01);
    for (int off = 0; off < 12; off++) begin
      wr(3'd2, 8'h10);
      wr(3'd0, 8'h01);
      repeat (off + 3) @(negedge clk);
      wr(3'd2, 8'h50);
      wr(3'd0, 8'h0A);
      rd(3'd2, r);
      check("R12 write priority", int'(r == 8'h50 || r == 8'h51), 1);
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule